// File: doc/BRIEF.md
# 100 Mbps Receive Carrier Detector

This block watches the serial code-bit stream of a 100 Mbps receiver, one code bit per valid cycle, and raises a carrier-present flag of the kind a reduced-pin MAC interface uses as its combined carrier-sense and data-valid signal. It declares carrier as soon as two zeros that are not next to each other sit within the last ten code bits. It does not wait for symbol or nibble alignment.

Once raised, the flag stays up until an external loss-of-carrier indication arrives. That indication drops the flag on the next clock edge and refills the bit history with ones, so zeros seen before the loss never count toward a later detection. The block does no decoding, descrambling or alignment. It only produces the flag.

Top module: `crs_carrier_detect`

## Requirements
- R1: While reset is applied and after it, carrierSense is 0 and the bit history holds all ones, so a single zero followed by ones never raises carrierSense.
- R2: When a valid code bit of 0 completes two zeros whose bit distance is at least 2 within the last 10 valid bits (the new bit included), carrierSense is 1 after that same clock edge.
- R3: Two zeros in consecutive valid bits, with no other zero in the 10-bit window, do not raise carrierSense.
- R4: Zeros at a distance of 9 valid bits (both inside a 10-bit window) raise carrierSense; zeros at a distance of 10 or more do not.
- R5: When bitValid is 0, codeBit is ignored. It neither enters the history nor changes carrierSense.
- R6: Once carrierSense is 1, it stays 1 for as long as carrierLost is 0, whatever the code bits are.
- R7: When carrierLost is 1 at a clock edge, carrierSense is 0 after that edge and the history returns to all ones.
- R8: carrierLost takes priority over a detection in the same cycle. carrierSense stays 0, and the code bit presented in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Synchronous active-low reset |
| bitValid | input | 1 | codeBit carries a new code bit this cycle |
| codeBit | input | 1 | Serial received code bit |
| carrierLost | input | 1 | Loss-of-carrier indication, one cycle or longer |
| carrierSense | output | 1 | Carrier-present flag |

## Verification
The assertions assume that bitValid and codeBit are settled at each rising edge and that a code bit counts only in a cycle where bitValid is high. They also assume that carrierLost may arrive at any time, including together with a valid bit. The stimulus drives every input on the falling edge, so each value holds steady across the next rising edge. The directed phases place zeros at distances 1, 2, 9 and 10, present zeros while bitValid is low, and apply carrierLost together with a completing zero. A long phase of mostly-one random bits, with invalid cycles and occasional loss events mixed in, is then compared against a queue-based model on every cycle.

// File: rtl/crs_detect_pkg.sv
package crs_detect_pkg;

  // Strobes from the control to the history datapath
  typedef struct packed {
    logic shiftEn;
    logic clearHist;
  } histCtrl_t;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_CARRIER = 1'b1
  } crsState_t;

endpackage

// File: rtl/crs_window_dp.sv
module crs_window_dp
  import crs_detect_pkg::*;
#(
  parameter int WIN = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  histCtrl_t ctrl,
  input  logic      codeBit,
  output logic      pairHit
);

  localparam int PAIRS = WIN - 2;

  logic [WIN-1:0]   history;
  logic [WIN-1:0]   candHist;
  logic [WIN-1:0]   zeroMap;
  logic [PAIRS-1:0] farHit;

  // Window the detector sees if the current bit is accepted
  assign candHist = {history[WIN-2:0], codeBit};
  assign zeroMap  = ~candHist;

  // For each position, look for another zero at least two places older
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    localparam logic [WIN-1:0] FAR_MASK = {WIN{1'b1}} << (i + 2);
    assign farHit[i] = zeroMap[i] & (|(zeroMap & FAR_MASK));
  end

  assign pairHit = |farHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      history <= '1;
    end else if (ctrl.clearHist) begin
      history <= '1;
    end else if (ctrl.shiftEn) begin
      history <= candHist;
    end
  end

  // R7: a clear strobe leaves an all-ones history
  a_r7_history_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearHist |=> (history == '1));

  // R1: fewer than two zeros can never form a hit
  a_r1_single_zero_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(zeroMap) < 2) |-> !pairHit);

  // R5: with no shift and no clear the history holds
  a_r5_history_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.shiftEn && !ctrl.clearHist) |=> $stable(history));

endmodule

// File: rtl/crs_ctrl.sv
module crs_ctrl
  import crs_detect_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitValid,
  input  logic      carrierLost,
  input  logic      pairHit,
  output histCtrl_t ctrl,
  output logic      carrierSense
);

  crsState_t state, stateNext;

  always_comb begin
    ctrl.clearHist = carrierLost;
    ctrl.shiftEn   = bitValid && !carrierLost;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (!carrierLost && bitValid && pairHit) stateNext = ST_CARRIER;
      end
      ST_CARRIER: begin
        if (carrierLost) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign carrierSense = (state == ST_CARRIER);

  // R6: flag is sticky while no loss is reported
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (carrierSense && !carrierLost) |=> carrierSense);

  // R7/R8: loss always leaves the flag low after the edge
  a_r7_loss_drops: assert property (@(posedge clk) disable iff (!rstN)
    carrierLost |=> !carrierSense);

  // R5: no valid bit, no rise
  a_r5_no_rise_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !carrierSense) |=> !carrierSense);

endmodule

// File: rtl/crs_carrier_detect.sv
module crs_carrier_detect
  import crs_detect_pkg::*;
#(
  parameter int WIN = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic codeBit,
  input  logic carrierLost,
  output logic carrierSense
);

  histCtrl_t histCtrl;
  logic      pairHit;

  crs_window_dp #(.WIN(WIN)) window_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (histCtrl),
    .codeBit (codeBit),
    .pairHit (pairHit)
  );

  crs_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .bitValid     (bitValid),
    .carrierLost  (carrierLost),
    .pairHit      (pairHit),
    .ctrl         (histCtrl),
    .carrierSense (carrierSense)
  );

  // R2: a rise needs a valid zero in the cycle before, and no loss
  a_r2_rise_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carrierSense) |-> ($past(bitValid) && !$past(codeBit) && !$past(carrierLost)));

endmodule

// File: tb/crs_carrier_detect_tb_top.sv
module crs_carrier_detect_tb_top;

  localparam int WIN = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0;
  logic codeBit = 1'b1;
  logic carrierLost = 1'b0;
  logic carrierSense;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int  refHist[$];
  bit  expSense = 1'b0;

  always #2 clk = ~clk;

  crs_carrier_detect #(.WIN(WIN)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .bitValid     (bitValid),
    .codeBit      (codeBit),
    .carrierLost  (carrierLost),
    .carrierSense (carrierSense)
  );

  function automatic bit modelHit();
    int zpos[$];
    for (int k = 0; k < refHist.size(); k++)
      if (refHist[k] == 0) zpos.push_back(k);
    for (int a = 0; a < zpos.size(); a++)
      for (int b = a + 1; b < zpos.size(); b++)
        if (zpos[b] - zpos[a] >= 2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic modelClear();
    refHist.delete();
    for (int k = 0; k < WIN; k++) refHist.push_back(1);
  endtask

  task automatic modelStep(bit v, bit b, bit l);
    if (l) begin
      expSense = 1'b0;
      modelClear();
    end else if (v) begin
      refHist.push_back(int'(b));
      void'(refHist.pop_front());
      if (!expSense && modelHit()) expSense = 1'b1;
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (carrierSense !== expSense) begin
      errors++;
      $display("FAIL %s: carrierSense actual %0b expected %0b at %0t", tag, carrierSense, expSense, $time);
    end
  endtask

  // Called at a falling edge; applies inputs for one rising edge
  task automatic step(bit v, bit b, bit l, string tag);
    bitValid = v; codeBit = b; carrierLost = l;
    @(posedge clk);
    modelStep(v, b, l);
    @(negedge clk);
    check(tag);
  endtask

  task automatic ones(int n, string tag);
    for (int k = 0; k < n; k++) step(1'b1, 1'b1, 1'b0, tag);
  endtask

  task automatic lose();
    step(1'b0, 1'b1, 1'b1, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");

    // R1: single zero after reset never detects
    step(1'b1, 1'b0, 1'b0, "R1");
    ones(12, "R1");

    // R3: adjacent pair alone
    lose();
    step(1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, "R3");
    ones(10, "R3");

    // R2: distance two detects on the completing edge
    lose();
    step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, "R2");
    // R6: sticky through ones and zeros
    ones(15, "R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, "R6");
    // R7: loss drops the flag
    lose();
    step(1'b0, 1'b1, 1'b0, "R7");

    // R4: distance 9 detects
    step(1'b1, 1'b0, 1'b0, "R4");
    ones(8, "R4");
    step(1'b1, 1'b0, 1'b0, "R4");
    lose();
    // R4: distance 10 does not
    step(1'b1, 1'b0, 1'b0, "R4");
    ones(9, "R4");
    step(1'b1, 1'b0, 1'b0, "R4");
    ones(3, "R4");
    lose();

    // R5: zeros while bitValid is low are ignored
    step(1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b0, "R5");
    lose();

    // R7: loss clears the history
    step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, "R7");
    ones(4, "R7");
    lose();

    // R8: loss beats a completing zero, and that bit is discarded
    step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    ones(3, "R8");

    // Mixed random stream against the model
    for (int n = 0; n < 3000; n++) begin
      bit v = ($urandom % 5) != 0;
      bit b = ($urandom % 6) != 0;
      bit l = ($urandom % 40) == 0;
      step(v, b, l, "R2/R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule